// File: doc/BRIEF.md
# Loop Reference Rate Generator

This block derives the comparison rates for two phase-locked loops, a transmit loop and a receive loop, from one crystal-derived clock. A programmable down-counter divides the clock by a 12-bit value and gives the base rate A. A divide-by-4 stage gives rate B from A, and a divide-by-25 stage gives rate C from B, so C is A/100. A 2-bit region select chooses which of A, B or C goes to each loop. The two loops can use different rates, so one loop can run at A/4 while the other runs at A/100.

Each output is a one-cycle strobe synchronous to `clk`, and each strobe is registered. Two tap outputs let a test pin observe the faster and the slower internal rates. The divide value and the region select are taken only at a terminal count of the base counter. Software can therefore rewrite them at any time without making a short period. All pins are plain control and status pins, so no handshake applies.

Top module: `ref_rate_gen`

## Requirements
- R1: While `rst_n` is low, all four strobe outputs are 0. After reset the divide value is 2048 and the select is treated as 00, so the first `tx_ref_stb` is seen exactly 2048 clock cycles after the first rising edge with `rst_n` high.
- R2: For a divide value N in the range 16..4095, the base rate A gives one strobe every N clock cycles.
- R3: A divide value below 16 behaves as 16.
- R4: Rate B gives one strobe on every 4th A strobe, and rate C gives one strobe on every 25th B strobe.
- R5: `region_sel` = 00 (bit 1 = S1, bit 0 = S0) routes A to both `tx_ref_stb` and `rx_ref_stb`.
- R6: `region_sel` = 01 routes B to both outputs.
- R7: `region_sel` = 10 routes B to `tx_ref_stb` and C to `rx_ref_stb`.
- R8: `region_sel` = 11 routes C to `tx_ref_stb` and B to `rx_ref_stb`.
- R9: `fr1_stb` carries A when S1 = 0 and B when S1 = 1. `fr2_stb` carries B when S1 = 0 and C when S1 = 1.
- R10: Every strobe lasts one cycle. Strobes of different rates that fall on the same base terminal count appear in the same cycle, so every `fr2_stb` comes with an `fr1_stb`.
- R11: The divide value and the select are sampled at the base terminal count. A change made in the middle of a period does not alter that period, and it takes effect from the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-derived clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_value | input | 12 | Base divide value (16..4095) |
| region_sel | input | 2 | Region select {S1,S0} |
| tx_ref_stb | output | 1 | Transmit loop reference strobe |
| rx_ref_stb | output | 1 | Receive loop reference strobe |
| fr1_stb | output | 1 | Faster tap strobe (A or B) |
| fr2_stb | output | 1 | Slower tap strobe (B or C) |

## Verification
A wrong base count shows up at once as a wrong spacing of `fr1_stb`, one period after the fault. A divide-by-4 or divide-by-25 stage that is out of phase or has the wrong modulus shifts or stretches the B and C strobes. This can take up to 100 base periods to appear, so the bench settles two full periods of the slowest output it observes before it measures. A routing error shows up as a wrong period on one loop output at the first strobe after the next terminal count. Sampling the divide value anywhere other than at the terminal count shows up as a changed length of the period in progress.

// File: rtl/ref_rate_pkg.sv
package ref_rate_pkg;

  typedef enum logic [1:0] {
    TAP_A = 2'd0,
    TAP_B = 2'd1,
    TAP_C = 2'd2
  } tap_e;

  function automatic tap_e tx_tap(input logic [1:0] sel);
    case (sel)
      2'b00:   return TAP_A;
      2'b01:   return TAP_B;
      2'b10:   return TAP_B;
      default: return TAP_C;
    endcase
  endfunction

  function automatic tap_e rx_tap(input logic [1:0] sel);
    case (sel)
      2'b00:   return TAP_A;
      2'b01:   return TAP_B;
      2'b10:   return TAP_C;
      default: return TAP_B;
    endcase
  endfunction

  function automatic tap_e fast_tap(input logic [1:0] sel);
    return sel[1] ? TAP_B : TAP_A;
  endfunction

  function automatic tap_e slow_tap(input logic [1:0] sel);
    return sel[1] ? TAP_C : TAP_B;
  endfunction

  function automatic logic pick(input tap_e t, input logic a, input logic b, input logic c);
    case (t)
      TAP_A:   return a;
      TAP_B:   return b;
      default: return c;
    endcase
  endfunction

endpackage

// File: rtl/base_divider.sv
module base_divider #(
  parameter int W   = 12,
  parameter int DEF = 2048,
  parameter int MIN = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] div_value,
  output logic         tc
);
  localparam logic [W-1:0] MIN_V  = W'(MIN);
  localparam logic [W-1:0] INIT_V = W'(DEF - 1);

  logic [W-1:0] cnt;
  logic [W-1:0] eff;

  assign tc  = (cnt == '0);
  assign eff = (div_value < MIN_V) ? MIN_V : div_value;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt <= INIT_V;
    else if (tc) cnt <= eff - W'(1);
    else         cnt <= cnt - W'(1);
  end
endmodule

// File: rtl/prescale_stage.sv
module prescale_stage #(
  parameter int MOD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_stb,
  output logic out_stb
);
  localparam int CW = (MOD > 1) ? $clog2(MOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(MOD - 1);

  logic [CW-1:0] cnt;

  assign out_stb = in_stb && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (out_stb) cnt <= '0;
    else if (in_stb)  cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/rate_router.sv
module rate_router
  import ref_rate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       a_stb,
  input  logic       b_stb,
  input  logic       c_stb,
  input  logic [1:0] sel,
  output logic       tx_stb,
  output logic       rx_stb,
  output logic       fast_stb,
  output logic       slow_stb
);
  logic tx_d, rx_d, fast_d, slow_d;

  always_comb begin
    tx_d   = pick(tx_tap(sel),   a_stb, b_stb, c_stb);
    rx_d   = pick(rx_tap(sel),   a_stb, b_stb, c_stb);
    fast_d = pick(fast_tap(sel), a_stb, b_stb, c_stb);
    slow_d = pick(slow_tap(sel), a_stb, b_stb, c_stb);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_stb   <= 1'b0;
      rx_stb   <= 1'b0;
      fast_stb <= 1'b0;
      slow_stb <= 1'b0;
    end else begin
      tx_stb   <= tx_d;
      rx_stb   <= rx_d;
      fast_stb <= fast_d;
      slow_stb <= slow_d;
    end
  end
endmodule

// File: rtl/ref_rate_gen.sv
module ref_rate_gen #(
  parameter int DIV_W   = 12,
  parameter int DIV_DEF = 2048,
  parameter int DIV_MIN = 16,
  parameter int B_MOD   = 4,
  parameter int C_MOD   = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_value,
  input  logic [1:0]       region_sel,
  output logic             tx_ref_stb,
  output logic             rx_ref_stb,
  output logic             fr1_stb,
  output logic             fr2_stb
);
  logic a_tc, b_tc, c_tc;

  base_divider #(.W(DIV_W), .DEF(DIV_DEF), .MIN(DIV_MIN)) u_base (
    .clk(clk), .rst_n(rst_n), .div_value(div_value), .tc(a_tc)
  );

  prescale_stage #(.MOD(B_MOD)) u_by_b (
    .clk(clk), .rst_n(rst_n), .in_stb(a_tc), .out_stb(b_tc)
  );

  prescale_stage #(.MOD(C_MOD)) u_by_c (
    .clk(clk), .rst_n(rst_n), .in_stb(b_tc), .out_stb(c_tc)
  );

  // Strobes exist only at a base terminal count, so the select is used only then.
  rate_router u_route (
    .clk(clk), .rst_n(rst_n),
    .a_stb(a_tc), .b_stb(b_tc), .c_stb(c_tc), .sel(region_sel),
    .tx_stb(tx_ref_stb), .rx_stb(rx_ref_stb),
    .fast_stb(fr1_stb), .slow_stb(fr2_stb)
  );
endmodule

// File: rtl/ref_rate_chk.sv
module ref_rate_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_ref_stb,
  input logic rx_ref_stb,
  input logic fr1_stb,
  input logic fr2_stb
);
  logic [7:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            gap <= 8'hFF;
    else if (fr1_stb)      gap <= 8'd0;
    else if (gap != 8'hFF) gap <= gap + 8'd1;
  end

  // R1
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!tx_ref_stb && !rx_ref_stb && !fr1_stb && !fr2_stb);
    end
  end

  // R10
  tx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ref_stb |=> !tx_ref_stb);

  // R10
  rx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ref_stb |=> !rx_ref_stb);

  // R9
  slow_with_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fr2_stb |-> fr1_stb);

  // R5
  tx_on_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ref_stb |-> fr1_stb);

  // R7
  rx_on_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ref_stb |-> fr1_stb);

  // R3
  min_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fr1_stb |-> (gap >= 8'd15));
endmodule

bind ref_rate_gen ref_rate_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .tx_ref_stb(tx_ref_stb), .rx_ref_stb(rx_ref_stb),
  .fr1_stb(fr1_stb), .fr2_stb(fr2_stb)
);

// File: tb/sim_ref_rate_gen.sv
module sim_ref_rate_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] div_value;
  logic [1:0]  region_sel;
  logic        tx_ref_stb, rx_ref_stb, fr1_stb, fr2_stb;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ref_rate_gen u0 (
    .clk(clk), .rst_n(rst_n), .div_value(div_value), .region_sel(region_sel),
    .tx_ref_stb(tx_ref_stb), .rx_ref_stb(rx_ref_stb),
    .fr1_stb(fr1_stb), .fr2_stb(fr2_stb)
  );

  localparam int TX = 0, RX = 1, F1 = 2, F2 = 3;
  localparam int LIMIT = 6000;

  function automatic logic sig(input int which);
    case (which)
      TX:      return tx_ref_stb;
      RX:      return rx_ref_stb;
      F1:      return fr1_stb;
      default: return fr2_stb;
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic period(input int which, output int p);
    int n = 0;
    while (!sig(which) && n < LIMIT) begin @(negedge clk); n++; end
    @(negedge clk);
    p = 1;
    while (!sig(which) && p < LIMIT) begin @(negedge clk); p++; end
  endtask

  task automatic settle(input int which);
    int p;
    period(which, p);
    period(which, p);
  endtask

  task automatic measure(input string req, input string what, input int which, input int exp);
    int p;
    settle(which);
    period(which, p);
    check(req, what, p, exp);
  endtask

  task automatic t_reset();
    int n = 0;
    int seen = 0;
    rst_n = 1'b0; div_value = 12'd2048; region_sel = 2'b00;
    repeat (3) @(negedge clk);
    check("R1", "outputs in reset", {tx_ref_stb, rx_ref_stb, fr1_stb, fr2_stb}, 0);
    rst_n = 1'b1;
    do begin
      @(negedge clk); n++;
      if (!tx_ref_stb && (rx_ref_stb || fr2_stb)) seen++;
    end while (!tx_ref_stb && n < 3000);
    check("R1", "cycles to first strobe", n, 2048);
    check("R1", "stray strobes", seen, 0);
  endtask

  task automatic t_base();
    region_sel = 2'b00;
    div_value = 12'd16;
    measure("R2", "tx period N=16", TX, 16);
    measure("R5", "rx period sel00", RX, 16);
    div_value = 12'd4095;
    measure("R2", "tx period N=4095", TX, 4095);
    div_value = 12'd5;
    measure("R3", "period N=5", F1, 16);
    div_value = 12'd0;
    measure("R3", "period N=0", F1, 16);
  endtask

  task automatic t_regions();
    div_value = 12'd16;
    region_sel = 2'b01;
    measure("R6", "tx sel01", TX, 64);
    measure("R6", "rx sel01", RX, 64);
    measure("R9", "fr1 sel01", F1, 16);
    measure("R4", "fr2 sel01 (B)", F2, 64);
    region_sel = 2'b10;
    measure("R7", "tx sel10", TX, 64);
    measure("R7", "rx sel10", RX, 1600);
    check("R10", "tx with rx strobe", tx_ref_stb, 1);
    measure("R9", "fr1 sel10", F1, 64);
    measure("R4", "fr2 sel10 (C)", F2, 1600);
    region_sel = 2'b11;
    measure("R8", "tx sel11", TX, 1600);
    check("R10", "fr1 with C strobe", fr1_stb, 1);
    measure("R8", "rx sel11", RX, 64);
  endtask

  task automatic t_sample_point();
    int p;
    region_sel = 2'b00;
    div_value = 12'd16;
    settle(TX);
    // now at the cycle a strobe is visible; the running period already holds 16
    div_value = 12'd40;
    period(TX, p);
    check("R11", "period after mid change", p, 16);
    period(TX, p);
    check("R11", "next period", p, 40);
    @(negedge clk);
    check("R10", "tx strobe one cycle", tx_ref_stb, 0);
  endtask

  initial begin
    t_reset();
    t_base();
    t_regions();
    t_sample_point();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule